// File: doc/BRIEF.md
# Vector Load/Store Element Address Sequencer

This block turns one decoded vector memory operation into an ordered stream of per-element effective addresses. When a command is launched it captures a base value, an immediate, a vector length, a source and a destination predicate mask, and flags that say which operands are vectors. It then walks the elements and emits, for each one, a 64-bit address, the source element position and the destination element position over a valid/ready handshake. Memory access, the data path and fault handling belong to other blocks.

Operand values come from a register file through two combinational read ports. The block drives a base-operand select and an index-operand select, and the register file answers in the same cycle. The addressing mode is chosen once at launch from the operand-vector flags, the stride-select bit and the immediate. The four element cursors (base/source, index, update and destination) each move on their own and skip masked-off positions only when their operand is a vector. For update forms every emitted address is also flagged for write-back at the update cursor's position.

The sequence ends when any active cursor runs out of set predicate bits below the vector length, or after the first element when the destination is scalar. A one-cycle done pulse then follows.

Top module: `vls_addr_seq`

## Requirements
- R1: For immediate forms (`rx_form_i`=0) the mode is picked in this priority order: a vector base selects vector-base mode, then `stride_sel_i`=0 selects unit stride, then a nonzero immediate selects element stride, and otherwise every element uses the single address base+immediate (splat).
- R2: In unit stride the address for source cursor i is base + imm + (i << `op_size_i`), with `op_size_i` 0,1,2,3 meaning 1,2,4,8 bytes. The base is read at select 0.
- R3: In element stride the address for source cursor i is base + i × imm, using a signed immediate and wrapping.
- R4: In vector-base mode the address is base[i] + imm, where base[i] is the register read with `base_sel_o` = i.
- R5: For register-indexed forms (`rx_form_i`=1), `rx_stride_i`=1 with both base and index scalar gives base + ext(index) × j, where j is the destination cursor. Every other case gives base[i] + ext(index[k]).
- R6: ext() takes the index from a width set by `src_ew_i` (0:8, 1:16, 2:32, 3:64 bits). It sign-extends that field when `signed_ea_i`=1 and zero-extends it otherwise. Bits above the field are ignored.
- R7: An operand that is a vector has a cursor that moves to the next set predicate bit at or above its position. Base, index and update cursors use the source mask; the destination cursor uses the destination mask. The source cursor is active for a vector base, unit stride and element stride. A scalar operand's cursor stays at 0, and its mask has no effect.
- R8: The run ends when any active cursor finds no set bit below the vector length. `done_o` pulses for exactly one cycle after the last element, with `busy_o` low and no valid output in that cycle.
- R9: With a scalar destination exactly one element is emitted. A register-indexed access with base and index both scalar and no stride emits exactly one element.
- R10: A vector length of 0 emits no element, and `done_o` is high in the second cycle after launch.
- R11: When `upd_en_i`=1, `upd_valid_o` accompanies every element. `upd_idx_o` is the update cursor position, which follows the source mask when `upd_vec_i`=1 and is 0 otherwise.
- R12: While `elem_valid_o` is high and `elem_ready_i` is low, the address and both indices hold their values.
- R13: All address arithmetic wraps modulo 2^64.
- R14: `start_i` and all command inputs are ignored while `busy_o` is high. They are captured only on a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a command (taken when idle) |
| rx_form_i | input | 1 | 1: register-indexed form, 0: immediate form |
| base_vec_i | input | 1 | Base operand is a vector |
| index_vec_i | input | 1 | Index operand is a vector |
| dst_vec_i | input | 1 | Destination is a vector |
| upd_en_i | input | 1 | Update form: emit address write-back |
| upd_vec_i | input | 1 | Update destination is a vector |
| stride_sel_i | input | 1 | Immediate form: 0 unit stride, 1 element stride/splat |
| rx_stride_i | input | 1 | Register-indexed form: request element stride |
| signed_ea_i | input | 1 | Sign-extend the index operand |
| op_size_i | input | 2 | log2 of the access size in bytes |
| src_ew_i | input | 2 | Index element width: 8/16/32/64 bits |
| imm_i | input | 64 | Immediate offset or stride |
| vl_i | input | 7 | Vector length 0..64 |
| src_mask_i | input | 64 | Source predicate mask |
| dst_mask_i | input | 64 | Destination predicate mask |
| base_sel_o | output | 6 | Base operand element select |
| base_data_i | input | 64 | Base operand value for `base_sel_o` |
| index_sel_o | output | 6 | Index operand element select |
| index_data_i | input | 64 | Index operand value for `index_sel_o` |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| elem_valid_o | output | 1 | Element output valid |
| elem_ready_i | input | 1 | Element output accepted |
| ea_o | output | 64 | Element effective address |
| src_idx_o | output | 6 | Source element position |
| dst_idx_o | output | 6 | Destination element position |
| upd_valid_o | output | 1 | Write `ea_o` back to the update register |
| upd_idx_o | output | 6 | Update register element position |

## Verification
The assertions assume that the register file returns a value that depends only on the select, so a stalled element sees the same operand data in every cycle. They also assume that the consumer drives `elem_ready_i` with a defined level. The bench models the register file as an arithmetic function of the select and an offset that changes only between runs, so both assumptions hold. After each launch the bench also scrambles every command input, which keeps the bench within the stated contract and also exercises R14. Predicate masks carry random bits above the vector length to show that those bits are ignored.

// File: rtl/vls_pkg.sv
package vls_pkg;

   typedef enum logic [2:0] {
      AM_SPLAT     = 3'd0,
      AM_UNIT      = 3'd1,
      AM_ELEM      = 3'd2,
      AM_VBASE     = 3'd3,
      AM_RX        = 3'd4,
      AM_RX_STRIDE = 3'd5
   } am_e;

   localparam int unsigned CUR_SRC = 0;
   localparam int unsigned CUR_IDX = 1;
   localparam int unsigned CUR_UPD = 2;
   localparam int unsigned CUR_DST = 3;
   localparam int unsigned NUM_CUR = 4;

   function automatic am_e pick_mode(input logic rx, input logic base_vec,
                                     input logic idx_vec, input logic stride_sel,
                                     input logic rx_stride, input logic imm_nz);
      if (rx)
         return (rx_stride && !base_vec && !idx_vec) ? AM_RX_STRIDE : AM_RX;
      if (base_vec)    return AM_VBASE;
      if (!stride_sel) return AM_UNIT;
      if (imm_nz)      return AM_ELEM;
      return AM_SPLAT;
   endfunction

endpackage

// File: rtl/vls_cursor.sv
module vls_cursor #(
   parameter int unsigned VL_MAX = 64,
   localparam int unsigned CW    = $clog2(VL_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              adv_i,
   input  logic              active_i,
   input  logic [VL_MAX-1:0] mask_i,
   input  logic [CW-1:0]     vl_i,
   output logic [CW-1:0]     pos_o,
   output logic              exhausted_o
);

   logic [CW-1:0] pos_q;
   logic [CW-1:0] hit;
   logic          found;

   always_comb begin
      found = 1'b0;
      hit   = pos_q;
      for (int p = 0; p < VL_MAX; p++) begin
         if (!found && CW'(p) >= pos_q && CW'(p) < vl_i && mask_i[p]) begin
            found = 1'b1;
            hit   = CW'(p);
         end
      end
   end

   assign pos_o       = active_i ? hit : pos_q;
   assign exhausted_o = active_i && !found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (clear_i)
         pos_q <= '0;
      else if (adv_i && active_i && found)
         pos_q <= hit + CW'(1);
   end

endmodule

// File: rtl/vls_ea_calc.sv
module vls_ea_calc #(
   parameter int unsigned AW     = 64,
   parameter int unsigned VL_MAX = 64,
   localparam int unsigned CW    = $clog2(VL_MAX + 1)
) (
   input  vls_pkg::am_e   mode_i,
   input  logic [AW-1:0]  base_i,
   input  logic [AW-1:0]  index_i,
   input  logic [AW-1:0]  imm_i,
   input  logic [1:0]     op_size_i,
   input  logic [1:0]     src_ew_i,
   input  logic           signed_i,
   input  logic [CW-1:0]  src_pos_i,
   input  logic [CW-1:0]  dst_pos_i,
   output logic [AW-1:0]  ea_o
);
   import vls_pkg::*;

   logic [AW-1:0] idx_ext;
   logic [AW-1:0] i_w;
   logic [AW-1:0] j_w;

   always_comb begin
      case (src_ew_i)
         2'd0:    idx_ext = {{(AW-8){signed_i & index_i[7]}}, index_i[7:0]};
         2'd1:    idx_ext = {{(AW-16){signed_i & index_i[15]}}, index_i[15:0]};
         2'd2:    idx_ext = {{(AW-32){signed_i & index_i[31]}}, index_i[31:0]};
         default: idx_ext = index_i;
      endcase
   end

   assign i_w = {{(AW-CW){1'b0}}, src_pos_i};
   assign j_w = {{(AW-CW){1'b0}}, dst_pos_i};

   always_comb begin
      case (mode_i)
         AM_UNIT:      ea_o = base_i + imm_i + (i_w << op_size_i);
         AM_ELEM:      ea_o = base_i + i_w * imm_i;
         AM_RX:        ea_o = base_i + idx_ext;
         AM_RX_STRIDE: ea_o = base_i + idx_ext * j_w;
         default:      ea_o = base_i + imm_i;
      endcase
   end

endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq #(
   parameter int unsigned AW     = 64,
   parameter int unsigned VL_MAX = 64,
   localparam int unsigned CW    = $clog2(VL_MAX + 1),
   localparam int unsigned IW    = $clog2(VL_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rx_form_i,
   input  logic              base_vec_i,
   input  logic              index_vec_i,
   input  logic              dst_vec_i,
   input  logic              upd_en_i,
   input  logic              upd_vec_i,
   input  logic              stride_sel_i,
   input  logic              rx_stride_i,
   input  logic              signed_ea_i,
   input  logic [1:0]        op_size_i,
   input  logic [1:0]        src_ew_i,
   input  logic [AW-1:0]     imm_i,
   input  logic [CW-1:0]     vl_i,
   input  logic [VL_MAX-1:0] src_mask_i,
   input  logic [VL_MAX-1:0] dst_mask_i,
   output logic [IW-1:0]     base_sel_o,
   input  logic [AW-1:0]     base_data_i,
   output logic [IW-1:0]     index_sel_o,
   input  logic [AW-1:0]     index_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              elem_valid_o,
   input  logic              elem_ready_i,
   output logic [AW-1:0]     ea_o,
   output logic [IW-1:0]     src_idx_o,
   output logic [IW-1:0]     dst_idx_o,
   output logic              upd_valid_o,
   output logic [IW-1:0]     upd_idx_o
);
   import vls_pkg::*;

   if (AW < 33) begin : g_bad_aw
      $error("vls_addr_seq: AW must be at least 33");
   end
   if (VL_MAX < 2 || VL_MAX > 64) begin : g_bad_vl
      $error("vls_addr_seq: VL_MAX must be within 2..64");
   end

   // captured command
   logic              q_rx, q_base_vec, q_idx_vec, q_dst_vec, q_upd, q_upd_vec, q_signed;
   logic [1:0]        q_op_size, q_src_ew;
   logic [AW-1:0]     q_imm;
   logic [CW-1:0]     q_vl;
   logic [VL_MAX-1:0] q_src_mask, q_dst_mask;
   am_e               q_mode;

   logic busy_q, done_q;
   logic launch, fire, empty, stop_one, finish;

   logic [NUM_CUR-1:0] cur_act;
   logic [NUM_CUR-1:0] cur_exh;
   logic [CW-1:0]      cur_pos [NUM_CUR];

   assign launch = start_i && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_rx <= 1'b0; q_base_vec <= 1'b0; q_idx_vec <= 1'b0; q_dst_vec <= 1'b0;
         q_upd <= 1'b0; q_upd_vec <= 1'b0; q_signed <= 1'b0;
         q_op_size <= '0; q_src_ew <= '0; q_imm <= '0; q_vl <= '0;
         q_src_mask <= '0; q_dst_mask <= '0; q_mode <= AM_SPLAT;
      end else if (launch) begin
         q_rx       <= rx_form_i;
         q_base_vec <= base_vec_i;
         q_idx_vec  <= index_vec_i;
         q_dst_vec  <= dst_vec_i;
         q_upd      <= upd_en_i;
         q_upd_vec  <= upd_vec_i;
         q_signed   <= signed_ea_i;
         q_op_size  <= op_size_i;
         q_src_ew   <= src_ew_i;
         q_imm      <= imm_i;
         q_vl       <= vl_i;
         q_src_mask <= src_mask_i;
         q_dst_mask <= dst_mask_i;
         q_mode     <= pick_mode(rx_form_i, base_vec_i, index_vec_i, stride_sel_i,
                                 rx_stride_i, |imm_i);
      end
   end

   assign cur_act[CUR_SRC] = q_base_vec || q_mode == AM_UNIT || q_mode == AM_ELEM;
   assign cur_act[CUR_IDX] = q_rx && q_idx_vec;
   assign cur_act[CUR_UPD] = q_upd && q_upd_vec;
   assign cur_act[CUR_DST] = q_dst_vec;

   for (genvar c = 0; c < NUM_CUR; c++) begin : g_cur
      logic [VL_MAX-1:0] msk;
      if (c == CUR_DST) begin : g_dmask
         assign msk = q_dst_mask;
      end else begin : g_smask
         assign msk = q_src_mask;
      end
      vls_cursor #(.VL_MAX(VL_MAX)) u_cur (
         .clk         (clk),
         .rst_n       (rst_n),
         .clear_i     (launch),
         .adv_i       (fire),
         .active_i    (cur_act[c]),
         .mask_i      (msk),
         .vl_i        (q_vl),
         .pos_o       (cur_pos[c]),
         .exhausted_o (cur_exh[c])
      );
   end

   assign empty    = (q_vl == '0) || (|cur_exh);
   assign stop_one = !q_dst_vec || (q_mode == AM_RX && !q_base_vec && !q_idx_vec);

   assign elem_valid_o = busy_q && !empty;
   assign fire         = elem_valid_o && elem_ready_i;
   assign finish       = busy_q && (empty || (fire && stop_one));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (launch)      busy_q <= 1'b1;
         else if (finish) busy_q <= 1'b0;
         done_q <= finish;
      end
   end

   assign base_sel_o  = q_base_vec ? cur_pos[CUR_SRC][IW-1:0] : '0;
   assign index_sel_o = q_idx_vec  ? cur_pos[CUR_IDX][IW-1:0] : '0;

   vls_ea_calc #(.AW(AW), .VL_MAX(VL_MAX)) u_ea (
      .mode_i    (q_mode),
      .base_i    (base_data_i),
      .index_i   (index_data_i),
      .imm_i     (q_imm),
      .op_size_i (q_op_size),
      .src_ew_i  (q_src_ew),
      .signed_i  (q_signed),
      .src_pos_i (cur_pos[CUR_SRC]),
      .dst_pos_i (cur_pos[CUR_DST]),
      .ea_o      (ea_o)
   );

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign src_idx_o   = cur_pos[CUR_SRC][IW-1:0];
   assign dst_idx_o   = cur_pos[CUR_DST][IW-1:0];
   assign upd_valid_o = elem_valid_o && q_upd;
   assign upd_idx_o   = cur_pos[CUR_UPD][IW-1:0];

endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
   parameter int unsigned AW     = 64,
   parameter int unsigned VL_MAX = 64,
   localparam int unsigned CW    = $clog2(VL_MAX + 1),
   localparam int unsigned IW    = $clog2(VL_MAX)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              elem_valid,
   input logic              elem_ready,
   input logic [AW-1:0]     ea,
   input logic [IW-1:0]     src_idx,
   input logic [IW-1:0]     dst_idx,
   input logic              busy,
   input logic              done,
   input logic              upd_valid,
   input logic              dst_vec,
   input logic [VL_MAX-1:0] dst_mask,
   input logic [CW-1:0]     vl
);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid && !elem_ready |=> elem_valid && $stable(ea) && $stable(src_idx) && $stable(dst_idx));

   assert_dst_pred_R7: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid && dst_vec |-> dst_mask[dst_idx] && ({1'b0, dst_idx} < vl));

   assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid && elem_ready && !dst_vec |=> !elem_valid);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !elem_valid);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_upd_with_elem_R11: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> elem_valid);

endmodule

bind vls_addr_seq vls_addr_seq_chk #(.AW(AW), .VL_MAX(VL_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .elem_valid (elem_valid_o),
   .elem_ready (elem_ready_i),
   .ea         (ea_o),
   .src_idx    (src_idx_o),
   .dst_idx    (dst_idx_o),
   .busy       (busy_o),
   .done       (done_o),
   .upd_valid  (upd_valid_o),
   .dst_vec    (q_dst_vec),
   .dst_mask   (q_dst_mask),
   .vl         (q_vl)
);

// File: tb/test_vls_addr_seq.sv
`timescale 1ns/1ps
module test_vls_addr_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rx = 1'b0, bvec = 1'b0, ivec = 1'b0, dvec = 1'b0, upd = 1'b0, uvec = 1'b0;
   logic        els = 1'b0, rxs = 1'b0, sgn = 1'b0;
   logic [1:0]  osz = '0, sew = '0;
   logic [63:0] imm = '0, smask = '0, dmask = '0, boff = 64'h0000_4000_0000_0000;
   logic [6:0]  vl = '0;
   logic        ready = 1'b0;

   logic [5:0]  base_sel, index_sel, src_idx, dst_idx, upd_idx;
   logic [63:0] base_data, index_data, ea;
   logic        busy, done, valid, upd_valid;

   int errors = 0, checks = 0;
   int unsigned lf = 32'h1234_5678;
   longint cycles = 0;
   bit wd = 0;

   always #2 clk = ~clk;

   function automatic logic [63:0] bval(input int s);
      return boff + 64'(s) * 64'h0000_0000_0001_0010;
   endfunction
   function automatic logic [63:0] ival(input int s);
      return {32'hA5C3_0F1E, 32'h8000_7F81 + 32'(s) * 32'h0101_0123};
   endfunction

   assign base_data  = bval(int'(base_sel));
   assign index_data = ival(int'(index_sel));

   vls_addr_seq i_vls_addr_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .rx_form_i(rx), .base_vec_i(bvec),
      .index_vec_i(ivec), .dst_vec_i(dvec), .upd_en_i(upd), .upd_vec_i(uvec),
      .stride_sel_i(els), .rx_stride_i(rxs), .signed_ea_i(sgn), .op_size_i(osz),
      .src_ew_i(sew), .imm_i(imm), .vl_i(vl), .src_mask_i(smask), .dst_mask_i(dmask),
      .base_sel_o(base_sel), .base_data_i(base_data), .index_sel_o(index_sel),
      .index_data_i(index_data), .busy_o(busy), .done_o(done), .elem_valid_o(valid),
      .elem_ready_i(ready), .ea_o(ea), .src_idx_o(src_idx), .dst_idx_o(dst_idx),
      .upd_valid_o(upd_valid), .upd_idx_o(upd_idx)
   );

   function automatic int unsigned rnd();
      lf = lf ^ (lf << 13);
      lf = lf ^ (lf >> 17);
      lf = lf ^ (lf << 5);
      return lf;
   endfunction

   function automatic logic [63:0] ext_idx(input logic [63:0] v);
      case (sew)
         2'd0:    return sgn ? {{56{v[7]}}, v[7:0]}   : {56'd0, v[7:0]};
         2'd1:    return sgn ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
         2'd2:    return sgn ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
         default: return v;
      endcase
   endfunction

   function automatic int nextpos(input bit act, input logic [63:0] m, input int cur);
      if (!act) return cur;
      for (int p = cur; p < int'(vl); p++) if (m[p]) return p;
      return -1;
   endfunction

   logic [63:0] exp_ea [65];
   int exp_src [65], exp_dst [65], exp_upd [65];
   int exp_n;

   // expected stream, built from the requirements
   task automatic build_model();
      int m, ci, ck, cu, cj;
      bit ai, ak, au;
      if (rx) m = (rxs && !bvec && !ivec) ? 5 : 4;   // R5
      else if (bvec) m = 3;                          // R1 priority
      else if (!els) m = 1;
      else if (imm != 0) m = 2;
      else m = 0;
      ai = bvec || m == 1 || m == 2;
      ak = rx && ivec;
      au = upd && uvec;
      ci = 0; ck = 0; cu = 0; cj = 0; exp_n = 0;
      while (vl != 0 && exp_n < 65) begin
         int ni, nk, nu, nj;
         logic [63:0] a;
         ni = nextpos(ai, smask, ci);
         nk = nextpos(ak, smask, ck);
         nu = nextpos(au, smask, cu);
         nj = nextpos(dvec, dmask, cj);
         if (ni < 0 || nk < 0 || nu < 0 || nj < 0) break;
         case (m)
            1: a = bval(0) + imm + (64'(ni) << osz);
            2: a = bval(0) + 64'(ni) * imm;
            3: a = bval(ni) + imm;
            4: a = bval(ni) + ext_idx(ival(nk));
            5: a = bval(0) + ext_idx(ival(0)) * 64'(nj);
            default: a = bval(0) + imm;
         endcase
         exp_ea[exp_n] = a; exp_src[exp_n] = ni; exp_dst[exp_n] = nj; exp_upd[exp_n] = nu;
         exp_n++;
         if (!dvec) break;
         if (m == 4 && !bvec && !ivec) break;
         if (ai) ci = ni + 1;
         if (ak) ck = nk + 1;
         if (au) cu = nu + 1;
         cj = nj + 1;
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   int done_cyc;

   // launch the current command and compare the whole stream
   task automatic run_case(input string tag, input bit poke, input int rdy_pct);
      int got, cyc;
      bit stall, fin, saw_u;
      logic [63:0] s_ea;
      logic [5:0] s_si, s_di;
      build_model();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = poke;
      // R14: command inputs are scrambled after launch
      vl = 7'd5; smask = ~smask; dmask = 64'h1; imm = ~imm; rx = ~rx; bvec = ~bvec;
      dvec = ~dvec; els = ~els; osz = ~osz; sew = ~sew; sgn = ~sgn; upd = ~upd;
      got = 0; cyc = 0; stall = 0; fin = 0; saw_u = 0;
      s_ea = '0; s_si = '0; s_di = '0;
      while (!fin && cyc < 300) begin
         cyc++;
         ready = (int'(rnd() % 100) < rdy_pct);
         #1;
         if (stall) begin
            check(valid && ea == s_ea && src_idx == s_si && dst_idx == s_di, "R12",
                  "stalled element changed", ea, s_ea);
         end
         stall = 0;
         if (valid) begin
            if (!ready) begin
               stall = 1; s_ea = ea; s_si = src_idx; s_di = dst_idx;
            end else begin
               if (got >= exp_n) begin
                  check(0, tag, "extra element", 64'(got), 64'(exp_n));
               end else begin
                  check(ea == exp_ea[got], tag, "address", ea, exp_ea[got]);
                  check(src_idx == 6'(exp_src[got]) && dst_idx == 6'(exp_dst[got]), tag,
                        "src/dst index", {src_idx, dst_idx}, {6'(exp_src[got]), 6'(exp_dst[got])});
                  if (upd_valid) begin
                     saw_u = 1;
                     check(upd_idx == 6'(exp_upd[got]), "R11", "update index",
                           64'(upd_idx), 64'(exp_upd[got]));
                  end
               end
               got++;
            end
         end
         if (done) begin
            fin = 1; done_cyc = cyc;
            check(!busy, "R8", "busy with done", 64'(busy), 64'd0);
         end
         @(negedge clk);
         start = 1'b0;
      end
      check(fin && got == exp_n, tag, "element count", 64'(got), 64'(exp_n));
      check(!done, "R8", "done longer than one cycle", 64'(done), 64'd0);
      if (~upd && exp_n > 0) check(saw_u, "R11", "update flag missing", 64'(saw_u), 64'd1);
   endtask

   task automatic set_cmd(input bit r, input bit bv, input bit iv, input bit dv,
                          input bit e, input bit rs, input logic [63:0] im,
                          input logic [6:0] l);
      rx = r; bvec = bv; ivec = iv; dvec = dv; els = e; rxs = rs; imm = im; vl = l;
      upd = 1'b0; uvec = 1'b0; sgn = 1'b0; osz = 2'd0; sew = 2'd3;
      smask = '1; dmask = '1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !wd) begin
         wd = 1;
         errors++; checks++;
         $display("FAIL R8 watchdog expired actual=%0d expected=<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !valid && !done, "R8", "reset state", {busy, valid, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !valid && !done, "R8", "idle after reset", {busy, valid, done}, 64'd0);

      // R10: empty vector
      set_cmd(0, 0, 0, 1, 0, 0, 64'h40, 7'd0);
      run_case("R10", 0, 100);
      check(done_cyc == 2, "R10", "done latency", 64'(done_cyc), 64'd2);

      // sweep: modes x vector lengths x sizes, random masks and ready
      for (int v = 0; v < 6; v++) begin
         for (int l = 1; l <= 9; l++) begin
            for (int s = 0; s < 4; s++) begin
               string tg;
               case (v)
                  0: begin set_cmd(0, 0, 0, 1, 0, 0, 64'h18, 7'(l)); tg = "R2"; end
                  1: begin set_cmd(0, 0, 0, 1, 1, 0, (s[0] ? -64'sd24 : 64'd40), 7'(l)); tg = "R3"; end
                  2: begin set_cmd(0, 1, 0, 1, s[1], 0, 64'h7, 7'(l)); tg = "R4"; end
                  3: begin set_cmd(0, 0, 0, 1, 1, 0, 64'h0, 7'(l)); tg = "R1"; end
                  4: begin set_cmd(1, rnd() % 2 == 0, 1, 1, 0, 0, 64'h0, 7'(l)); tg = "R6"; end
                  default: begin set_cmd(1, 0, 0, 1, 0, 1, 64'h0, 7'(l)); tg = "R5"; end
               endcase
               osz = 2'(s); sew = 2'(s); sgn = rnd() % 2 == 0;
               smask = {rnd(), rnd()} | {rnd(), rnd()};
               dmask = {rnd(), rnd()} | {rnd(), rnd()};
               upd = rnd() % 2 == 0; uvec = rnd() % 2 == 0;
               run_case(tg, 0, 70);
            end
         end
      end

      // R9: scalar destination gives one element
      set_cmd(0, 0, 0, 0, 0, 0, 64'h20, 7'd8);
      run_case("R9", 0, 100);
      // R9: register-indexed, both scalar, no stride
      set_cmd(1, 0, 0, 1, 0, 0, 64'h0, 7'd8);
      run_case("R9", 0, 100);
      // R1: vector base wins over stride select and nonzero immediate
      set_cmd(0, 1, 0, 1, 1, 0, 64'h100, 7'd4);
      run_case("R1", 0, 100);
      // R7: splat ignores the source mask; sparse destination mask
      set_cmd(0, 0, 0, 1, 1, 0, 64'h0, 7'd10);
      smask = 64'h0; dmask = 64'h0000_0000_0000_0249;
      run_case("R7", 0, 100);
      // R8: source cursor runs out before the destination cursor
      set_cmd(0, 0, 0, 1, 0, 0, 64'h8, 7'd12);
      smask = 64'hFFFF_FFFF_FFFF_F012;
      run_case("R8", 0, 100);
      // R11: vector update cursor
      set_cmd(0, 1, 0, 1, 0, 0, 64'h4, 7'd7);
      upd = 1'b1; uvec = 1'b1; smask = 64'h55;
      run_case("R11", 0, 60);
      // R6: signed 8-bit index versus unsigned
      set_cmd(1, 0, 1, 1, 0, 0, 64'h0, 7'd6);
      sew = 2'd0; sgn = 1'b1;
      run_case("R6", 0, 100);
      set_cmd(1, 0, 1, 1, 0, 0, 64'h0, 7'd6);
      sew = 2'd2; sgn = 1'b0;
      run_case("R6", 0, 100);
      // R13: wrap around the top of the address space
      boff = 64'hFFFF_FFFF_FFFF_FF00;
      set_cmd(0, 0, 0, 1, 0, 0, 64'hF0, 7'd6);
      osz = 2'd3;
      run_case("R13", 0, 100);
      set_cmd(0, 0, 0, 1, 1, 0, 64'h7FFF_FFFF_FFFF_FFF0, 7'd5);
      run_case("R13", 0, 100);
      boff = 64'h0000_4000_0000_0000;
      // R14: a second start while busy is ignored
      set_cmd(0, 0, 0, 1, 0, 0, 64'h30, 7'd9);
      run_case("R14", 1, 50);
      // R12: heavy back-pressure on a long run
      set_cmd(0, 1, 0, 1, 0, 0, 64'h2, 7'd64);
      smask = '1; dmask = '1;
      run_case("R12", 0, 25);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule